// File: doc/BRIEF.md
# MDIO Management Register Bridge

This block turns writes to a single 32-bit host access register into Clause-22 management transactions on an MDIO bus. The host puts a PHY register address into bits 23:16 and, for a write, the data into bits 15:0. Bit 31 selects the direction. When set, the block performs a PHY write, and bit 31 reads back as a busy flag that the block clears once the frame has gone out. When clear, the block performs a PHY read, and bit 31 reads back as a valid flag that the block sets once bits 15:0 hold the returned data. The management clock MDC is derived from the system clock. The PHY address is a fixed parameter.

The frame engine is a state machine with these states: ST_IDLE, ST_PRE (32 ones), ST_START (01), ST_OP (01 for write, 10 for read), ST_PHY (5-bit PHY address), ST_REG (5-bit register address), ST_TA (turnaround) and ST_DATA (16 bits, MSB first). The transitions are as follows:
- ST_IDLE moves to ST_PRE on the first MDC falling edge after a transfer is accepted.
- Each later state moves to the next one in the order listed on the MDC falling edge that ends its last bit.
- ST_DATA returns to ST_IDLE when its sixteenth bit ends. That same edge signals completion to the register.

Top module: `mdio_mgmt_bridge`

## Requirements
- R1: After reset the access register reads 0, MDC is low and MDIO is released (mdio_oe low).
- R2: An accepted host write with bit 31 set reads back the next cycle as {1, 7'b0, addr[7:0], data[15:0]}. When the frame has ended, bit 31 reads 0 and the other fields are unchanged.
- R3: A PHY write frame on the wire consists of the following, with every bit driven:
  - 32 ones
  - start 01
  - opcode 01
  - the PHY address parameter
  - register address bits 4:0
  - turnaround 10
  - the 16 data bits, MSB first
- R4: A PHY read (bit 31 written 0) reads bit 31 as 0 while in progress. At the end, bit 31 reads 1, bits 15:0 hold the 16 bits the PHY returned, and bits 23:16 are unchanged.
- R5: A PHY read frame drives 32 ones, start 01, opcode 10, the PHY address and register address bits 4:0. It then releases MDIO from the first turnaround bit through the last data bit.
- R6: All 8 bits of the written address field (bits 23:16) read back. Only bits 4:0 of it go on the bus. Bits 30:24 always read 0.
- R7: MDC has a period of CLK_DIV system clocks with equal high and low times. While driven, MDIO changes only in the cycle in which MDC falls.
- R8: Read data bits are captured on the rising edges of MDC.
- R9: A host write that arrives while a transfer is in progress is ignored. The register keeps its contents and the running frame completes unchanged.
- R10: A host write to any offset other than REG_OFFSET (0x60) is ignored and starts no frame.
- R11: MDIO is released whenever no transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_addr | input | ADDR_W | Host register offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Current contents of the access register |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO value seen from the pad |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The bench targets several corner cases, and each one shows up as a visible fault:
- The opposite meaning of bit 31 in the two directions. A design that treats both alike would leave a read flagged busy or a write flagged valid.
- The turnaround hand-over. A read that keeps driving into ST_TA would fight the PHY model and corrupt the returned data.
- The 8-bit address field against the 5-bit bus address. Register 0xE7 must read back as 0xE7 but reach the PHY as register 7.
- Overlapping host writes and writes to a wrong offset. Either one would otherwise rewrite the register or start a second frame that the PHY model would count.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_START,
        ST_OP,
        ST_PHY,
        ST_REG,
        ST_TA,
        ST_DATA
    } mdio_state_e;

    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] SOF_BITS  = 2'b01;
    localparam logic [1:0] TA_WRITE  = 2'b10;
    localparam int         FRAME_LEN = 64;

    // Index of the final bit in each frame phase.
    function automatic logic [4:0] phase_last(input mdio_state_e st);
        unique case (st)
            ST_PRE:   phase_last = 5'd31;
            ST_PHY:   phase_last = 5'd4;
            ST_REG:   phase_last = 5'd4;
            ST_DATA:  phase_last = 5'd15;
            default:  phase_last = 5'd1;
        endcase
    endfunction

    // Successor of each frame phase.
    function automatic mdio_state_e phase_next(input mdio_state_e st);
        unique case (st)
            ST_IDLE:  phase_next = ST_PRE;
            ST_PRE:   phase_next = ST_START;
            ST_START: phase_next = ST_OP;
            ST_OP:    phase_next = ST_PHY;
            ST_PHY:   phase_next = ST_REG;
            ST_REG:   phase_next = ST_TA;
            ST_TA:    phase_next = ST_DATA;
            default:  phase_next = ST_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_q;
    logic          wrap;

    assign wrap = (cnt_q == CW'(HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Ticks mark the system-clock edge on which MDC changes level.
    assign rise_tick = wrap & ~mdc;
    assign fall_tick = wrap &  mdc;

    generate
        if (HALF > 1) begin : g_hold
            // R7
            mdc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !$stable(mdc) |=> $stable(mdc));
        end
    endgenerate

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
#(
    parameter logic [4:0] PHY_ADDR = 5'd1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        is_write,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] wdata,
    input  logic        mdc,
    input  logic        rise_tick,
    input  logic        fall_tick,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic [15:0] rdata,
    output logic        done
);
    mdio_state_e          state_q, state_d;
    logic [4:0]           cnt_q, cnt_d;
    logic                 last;
    logic                 pend_q;
    logic                 wr_q;
    logic [FRAME_LEN-1:0] sr_q;
    logic [15:0]          rd_q;

    assign last = (cnt_q == phase_last(state_q));

    // Next-state logic: phases advance on MDC falling edges.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pend_q && fall_tick) begin
                    state_d = ST_PRE;
                    cnt_d   = '0;
                end
            end
            ST_PRE, ST_START, ST_OP, ST_PHY, ST_REG, ST_TA, ST_DATA: begin
                if (fall_tick) begin
                    if (last) begin
                        state_d = phase_next(state_q);
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 5'd1;
                    end
                end
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Frame shifter and read-data capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            wr_q   <= 1'b0;
            sr_q   <= '0;
            rd_q   <= '0;
        end else begin
            if (start && state_q == ST_IDLE && !pend_q) begin
                pend_q <= 1'b1;
                wr_q   <= is_write;
                sr_q   <= {{32{1'b1}}, SOF_BITS,
                           is_write ? OPC_WRITE : OPC_READ,
                           PHY_ADDR, reg_addr, TA_WRITE, wdata};
            end else if (state_q == ST_IDLE && fall_tick) begin
                pend_q <= 1'b0;
            end
            if (state_q != ST_IDLE && fall_tick) begin
                sr_q <= {sr_q[FRAME_LEN-2:0], 1'b0};
            end
            if (state_q == ST_DATA && rise_tick && !wr_q) begin
                rd_q <= {rd_q[14:0], mdio_i};
            end
        end
    end

    // Outputs.
    always_comb begin
        mdio_o  = sr_q[FRAME_LEN-1];
        rdata   = rd_q;
        done    = (state_q == ST_DATA) && fall_tick && last;
        unique case (state_q)
            ST_IDLE:               mdio_oe = 1'b0;
            ST_TA, ST_DATA:        mdio_oe = wr_q;
            default:               mdio_oe = 1'b1;
        endcase
    end

    // R7
    mdio_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && $past(mdio_oe) && !$stable(mdio_o)) |-> $fell(mdc));

endmodule

// File: rtl/mdio_mgmt_bridge.sv
module mdio_mgmt_bridge
    import mdio_mgmt_pkg::*;
#(
    parameter int         CLK_DIV    = 4,
    parameter int         ADDR_W     = 8,
    parameter logic [7:0] REG_OFFSET = 8'h60,
    parameter logic [4:0] PHY_ADDR   = 5'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              mdc,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe
);
    logic        flag_q;
    logic        mode_q;
    logic        busy_q;
    logic [7:0]  addr_q;
    logic [15:0] data_q;
    logic        accept;
    logic        rise_tick, fall_tick;
    logic        eng_done;
    logic [15:0] eng_rdata;
    logic [6:0]  unused_wbits;

    assign unused_wbits = host_wdata[30:24];
    assign accept = host_wr && (host_addr == ADDR_W'(REG_OFFSET)) && !busy_q;

    mdio_clk_div #(.CLK_DIV(CLK_DIV)) i_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_engine #(.PHY_ADDR(PHY_ADDR)) i_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .is_write  (host_wdata[31]),
        .reg_addr  (host_wdata[20:16]),
        .wdata     (host_wdata[15:0]),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rdata     (eng_rdata),
        .done      (eng_done)
    );

    // Access register: bit 31 is busy for writes, valid for reads.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            mode_q <= 1'b0;
            busy_q <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else if (accept) begin
            flag_q <= host_wdata[31];
            mode_q <= host_wdata[31];
            busy_q <= 1'b1;
            addr_q <= host_wdata[23:16];
            data_q <= host_wdata[15:0];
        end else if (eng_done) begin
            busy_q <= 1'b0;
            flag_q <= !mode_q;
            if (!mode_q) begin
                data_q <= eng_rdata;
            end
        end
    end

    assign host_rdata = {flag_q, 7'b0, addr_q, data_q};

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && host_wr) |=> $stable(addr_q));
    // R10
    offset_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && host_wr && host_addr != ADDR_W'(REG_OFFSET)) |=> ($stable(addr_q) && $stable(data_q)));
    // R11
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !mdio_oe);
    // R4
    read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && !mode_q) |=> flag_q);
    // R2
    write_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && mode_q) |=> !flag_q);

endmodule

// File: tb/test_mdio_mgmt_bridge.sv
module test_mdio_mgmt_bridge;
    localparam int CLK_DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    mdio_mgmt_bridge #(.CLK_DIV(CLK_DIV)) i_mdio_mgmt_bridge (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
        .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    // PHY model
    logic [15:0] phy_mem [32];
    logic [15:0] ref_mem [32];
    int          ones = 0, pos = 0, frames = 0;
    logic        in_frame = 1'b0, oe_bad = 1'b0;
    logic [13:0] hdr;
    logic [1:0]  last_op, last_ta;
    logic [4:0]  last_phy, last_reg;
    logic [15:0] wd;

    always @(posedge mdc) begin
        if (!in_frame) begin
            if (mdio_oe && mdio_o) ones = ones + 1;
            else if (mdio_oe && !mdio_o && ones >= 32) begin
                in_frame = 1'b1; pos = 0; hdr = '0; ones = 0; oe_bad = 1'b0;
            end else ones = 0;
        end else begin
            pos = pos + 1;
            if (pos <= 13) begin
                hdr = {hdr[12:0], mdio_o};
                if (!mdio_oe) oe_bad = 1'b1;
                if (pos == 13) begin
                    last_op = hdr[11:10]; last_phy = hdr[9:5]; last_reg = hdr[4:0];
                    if (hdr[13:12] != 2'b01) oe_bad = 1'b1;
                end
            end else if (last_op == 2'b01) begin
                if (!mdio_oe) oe_bad = 1'b1;
                if (pos <= 15) last_ta = {last_ta[0], mdio_o};
                else wd = {wd[14:0], mdio_o};
            end else if (mdio_oe) oe_bad = 1'b1;
            if (pos == 31) begin
                if (last_op == 2'b01 && last_phy == 5'd1) phy_mem[last_reg] = wd;
                frames = frames + 1;
                in_frame = 1'b0;
            end
        end
    end

    always @(negedge mdc) begin
        if (in_frame && last_op == 2'b10 && pos >= 15 && pos <= 30)
            mdio_i = phy_mem[last_reg][30-pos];
        else
            mdio_i = 1'b1;
    end

    // Edge-discipline monitor (R7) and release monitor (R10/R11)
    logic prev_o = 1'b0, prev_oe = 1'b0, prev_mdc = 1'b0, oe_seen = 1'b0;
    int   edge_viol = 0, cyc = 0, last_rise = 0, mdc_period = 0;
    always @(posedge clk) cyc = cyc + 1;
    always @(posedge mdc) begin mdc_period = cyc - last_rise; last_rise = cyc; end
    always @(negedge clk) begin
        if (rst_n && mdio_oe && prev_oe && mdio_o != prev_o && !(prev_mdc && !mdc))
            edge_viol = edge_viol + 1;
        if (mdio_oe) oe_seen = 1'b1;
        prev_o = mdio_o; prev_oe = mdio_oe; prev_mdc = mdc;
    end

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic wait_flag(input logic v);
        for (int n = 0; n < 2000 && host_rdata[31] !== v; n++) @(negedge clk);
    endtask

    // {write, reg addr, data}
    localparam logic [24:0] VECS [8] = '{
        25'h1_04_01E1, 25'h0_04_0000, 25'h1_09_0200, 25'h0_01_0000,
        25'h1_1F_FFFF, 25'h0_1F_0000, 25'h1_10_0000, 25'h0_00_0000
    };

    initial begin
        for (int i = 0; i < 32; i++) begin
            phy_mem[i] = 16'h5A00 | 16'(i * 3);
            ref_mem[i] = 16'h5A00 | 16'(i * 3);
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        check(host_rdata === 32'h0, "R1", host_rdata, 32'h0);
        check(mdio_oe === 1'b0 && mdc === 1'b0, "R1", {mdio_oe, mdc}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        for (int k = 0; k < 8; k++) begin
            logic       w;
            logic [7:0] ra;
            logic [15:0] d;
            {w, ra, d} = VECS[k];
            host_write(8'h60, {w, 7'b0, ra, d});
            if (w) begin
                check(host_rdata === {1'b1, 7'b0, ra, d}, "R2 busy", host_rdata, {1'b1, 7'b0, ra, d});
                wait_flag(1'b0);
                check(host_rdata === {1'b0, 7'b0, ra, d}, "R2 done", host_rdata, {1'b0, 7'b0, ra, d});
                check(phy_mem[ra[4:0]] === d, "R3 data", {16'h0, phy_mem[ra[4:0]]}, {16'h0, d});
                ref_mem[ra[4:0]] = d;
                check(last_op == 2'b01 && last_phy == 5'd1 && last_reg == ra[4:0] && last_ta == 2'b10 && !oe_bad,
                      "R3 frame", {16'h0, last_op, last_ta, last_phy, last_reg, oe_bad}, {16'h0, 2'b01, 2'b10, 5'd1, ra[4:0], 1'b0});
            end else begin
                check(host_rdata[31] === 1'b0, "R4 pending", host_rdata, {1'b0, 7'b0, ra, 16'h0});
                wait_flag(1'b1);
                check(host_rdata === {1'b1, 7'b0, ra, ref_mem[ra[4:0]]}, "R4 R8 data", host_rdata, {1'b1, 7'b0, ra, ref_mem[ra[4:0]]});
                check(last_op == 2'b10 && last_phy == 5'd1 && last_reg == ra[4:0] && !oe_bad,
                      "R5 frame", {16'h0, last_op, last_phy, last_reg, oe_bad}, {16'h0, 2'b10, 5'd1, ra[4:0], 1'b0});
            end
        end

        // R6: 8-bit field kept, low 5 bits sent
        host_write(8'h60, 32'h80E7_0E07);
        wait_flag(1'b0);
        check(host_rdata === 32'h00E7_0E07, "R6 field", host_rdata, 32'h00E7_0E07);
        check(last_reg == 5'd7 && phy_mem[7] === 16'h0E07, "R6 bus", {11'h0, last_reg, phy_mem[7]}, {11'h0, 5'd7, 16'h0E07});
        ref_mem[7] = 16'h0E07;
        host_write(8'h60, 32'h00E7_0000);
        wait_flag(1'b1);
        check(host_rdata === 32'h80E7_0E07, "R6 read", host_rdata, 32'h80E7_0E07);

        // R9: write during transfer ignored
        begin
            int f0;
            host_write(8'h60, 32'h8005_1234);
            repeat (60) @(negedge clk);
            f0 = frames;
            host_write(8'h60, 32'h8006_BEEF);
            check(host_rdata === 32'h8005_1234, "R9 reg", host_rdata, 32'h8005_1234);
            wait_flag(1'b0);
            repeat (400) @(negedge clk);
            check(frames == f0 + 1, "R9 frames", frames, f0 + 1);
            check(phy_mem[5] === 16'h1234 && phy_mem[6] === ref_mem[6], "R9 phy",
                  {phy_mem[5], phy_mem[6]}, {16'h1234, ref_mem[6]});
        end

        // R10: wrong offset ignored
        begin
            int f0;
            f0 = frames;
            oe_seen = 1'b0;
            host_write(8'h64, 32'h8007_7777);
            check(host_rdata === 32'h0005_1234, "R10 reg", host_rdata, 32'h0005_1234);
            repeat (400) @(negedge clk);
            check(frames == f0 && !oe_seen, "R10 idle", {frames[30:0], oe_seen}, {f0[30:0], 1'b0});
            check(mdio_oe === 1'b0, "R11 released", mdio_oe, 0);
        end

        check(mdc_period == CLK_DIV, "R7 period", mdc_period, CLK_DIV);
        check(edge_viol == 0, "R7 edges", edge_viol, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule